// File: doc/BRIEF.md
# Grouped Maskable Interrupt Controller

This block collects interrupt request lines from four groups of sixteen sources: local bus, LPC/serial IRQ, PCI and on-chip devices, and non-maskable events. Each source passes through a two-stage synchroniser. It is then treated as either a live level or a sticky edge event, with an active sense that software selects per bit. Every group keeps its own mask, trigger-mode, polarity and request register. The block forms one pending flag per group and drives two registered outputs. One goes to the processor's general interrupt line and the other to its non-maskable line.

Software reaches all registers through a synchronous port. A write takes effect at the next clock edge. A read returns data one cycle after the strobe, with a valid flag. Sticky edge requests are acknowledged by writing the request register. Any bit written as zero is cleared, so a single write of zero acknowledges a whole group at once, which is the normal use for the LPC group.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset every mask register reads 0xFFFF, every trigger and polarity register reads 0x0000, the summary reads 0 and both interrupt outputs are low.
- R2: Address bit 4 clear selects group addr[3:2] (0 local bus, 1 LPC, 2 PCI/device, 3 NMI) and field addr[1:0] (0 mask, 1 trigger, 2 polarity, 3 request). A write lands at the next clock edge. rd_valid_o and rdata_o follow a read strobe by one cycle.
- R3: A mask bit of 1 hides its source from the summary and the outputs, but the request register still shows that source.
- R4: A source whose trigger bit is 0 is level-sensitive. Its request bit shows the input live, active when the input equals the polarity bit (1 active-high, 0 active-low).
- R5: A source whose trigger bit is 1 sets a sticky request on its active edge: rising for polarity 1, falling for polarity 0. The request stays set after the input returns.
- R6: A write to a request register keeps only those latched bits written as 1. Writing 0 clears every latched request of the group at once. Level-sensitive bits are not affected.
- R7: An active edge that arrives in the same cycle as a request-register write leaves its latch set.
- R8: Address 0x10 reads the summary: bit 0 local bus, bit 1 LPC, bit 2 PCI/device, bit 3 NMI. Each bit is set when the group has an unmasked pending request.
- R9: irq_cpu_o is the registered OR of the local-bus, LPC and PCI/device summary bits. An NMI-group request alone never raises it.
- R10: irq_nmi_o is driven only by the NMI group's summary bit.
- R11: Writes to the summary address are ignored and leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, one cycle after the strobe |
| rd_valid_o | output | 1 | Read data valid |
| src_lb_i | input | 16 | Local-bus request lines |
| src_lpc_i | input | 16 | LPC/serial request lines |
| src_pci_i | input | 16 | PCI and device request lines |
| src_nmi_i | input | 16 | Non-maskable request lines |
| irq_cpu_o | output | 1 | Registered general interrupt output |
| irq_nmi_o | output | 1 | Registered non-maskable interrupt output |

## Verification
The properties assume that reset is held for at least one clock edge. They also assume that the strobes and address are stable around each rising edge. Edge events must hold their new level for at least two clocks, so the synchroniser cannot miss them. The stimulus changes request lines and strobes only on falling edges. Every pulse it drives lasts at least two cycles. It sets a source to its inactive level before it changes that source's polarity, so a polarity write never creates a false edge. The coincident acknowledge case is lined up by counting clock edges through the synchroniser.

// File: rtl/irq_grp_pkg.sv
package irq_grp_pkg;
  localparam int GRP_N   = 4;
  localparam int GRP_LB  = 0;
  localparam int GRP_LPC = 1;
  localparam int GRP_PCI = 2;
  localparam int GRP_NMI = 3;
  localparam int ADDR_W  = 5;
  localparam logic [ADDR_W-1:0] SUMMARY_ADDR = 5'h10;

  typedef enum logic [1:0] {
    FLD_MASK = 2'd0,
    FLD_TRIG = 2'd1,
    FLD_POL  = 2'd2,
    FLD_REQ  = 2'd3
  } fld_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/irq_group.sv
module irq_group #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src_i,
  input  logic         we_mask_i,
  input  logic         we_trig_i,
  input  logic         we_pol_i,
  input  logic         we_req_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] trig_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] req_o,
  output logic         pend_o
);
  logic [W-1:0] mask_q, trig_q, pol_q, latch_q, act_d_q;
  logic [W-1:0] active, rise, keep, latch_n;

  // active level after the per-bit polarity choice
  assign active  = ~(src_i ^ pol_q);
  assign rise    = active & ~act_d_q & trig_q;
  assign keep    = we_req_i ? wdata_i : '1;
  assign latch_n = (latch_q & keep) | rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '1;
      trig_q  <= '0;
      pol_q   <= '0;
      latch_q <= '0;
      act_d_q <= '0;
    end else begin
      if (we_mask_i) mask_q <= wdata_i;
      if (we_trig_i) trig_q <= wdata_i;
      if (we_pol_i)  pol_q  <= wdata_i;
      latch_q <= latch_n;
      act_d_q <= active;
    end
  end

  assign req_o  = (trig_q & latch_q) | (~trig_q & active);
  assign pend_o = |(req_o & ~mask_q);
  assign mask_o = mask_q;
  assign trig_o = trig_q;
  assign pol_o  = pol_q;

  // R1: configuration comes out of reset fully masked and level-sensitive
  p_mask_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mask_q == '1 && trig_q == '0 && pol_q == '0));

  // R6: a latch only drops when software writes the request register
  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(we_req_i) |-> ((latch_q & $past(latch_q)) == $past(latch_q)));

  // R7: an edge is never lost, even against a coincident acknowledge
  p_edge_kept_r7: assert property (@(posedge clk) disable iff (rst)
    (|rise) |=> ((latch_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl
  import irq_grp_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SRC_W-1:0]  wdata_i,
  output logic [SRC_W-1:0]  rdata_o,
  output logic              rd_valid_o,
  input  logic [SRC_W-1:0]  src_lb_i,
  input  logic [SRC_W-1:0]  src_lpc_i,
  input  logic [SRC_W-1:0]  src_pci_i,
  input  logic [SRC_W-1:0]  src_nmi_i,
  output logic              irq_cpu_o,
  output logic              irq_nmi_o
);
  localparam int ALL_W = GRP_N * SRC_W;

  logic [GRP_N-1:0][SRC_W-1:0] raw, synced;
  logic [GRP_N-1:0][SRC_W-1:0] mask_all, trig_all, pol_all, req_all;
  logic [GRP_N-1:0]            pend;
  logic [ALL_W-1:0]            synced_flat;
  logic                        grp_sel;
  logic [1:0]                  grp_idx;
  fld_e                        fld;

  assign raw[GRP_LB]  = src_lb_i;
  assign raw[GRP_LPC] = src_lpc_i;
  assign raw[GRP_PCI] = src_pci_i;
  assign raw[GRP_NMI] = src_nmi_i;

  irq_sync #(.W(ALL_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw),
    .q_o (synced_flat)
  );
  assign synced = synced_flat;

  assign grp_sel = !addr_i[4];
  assign grp_idx = addr_i[3:2];
  assign fld     = fld_e'(addr_i[1:0]);

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    logic hit;
    assign hit = wr_en_i && grp_sel && (grp_idx == 2'(g));
    irq_group #(.W(SRC_W)) u_grp (
      .clk       (clk),
      .rst       (rst),
      .src_i     (synced[g]),
      .we_mask_i (hit && fld == FLD_MASK),
      .we_trig_i (hit && fld == FLD_TRIG),
      .we_pol_i  (hit && fld == FLD_POL),
      .we_req_i  (hit && fld == FLD_REQ),
      .wdata_i   (wdata_i),
      .mask_o    (mask_all[g]),
      .trig_o    (trig_all[g]),
      .pol_o     (pol_all[g]),
      .req_o     (req_all[g]),
      .pend_o    (pend[g])
    );
  end

  logic [SRC_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (grp_sel) begin
      unique case (fld)
        FLD_MASK: rd_mux = mask_all[grp_idx];
        FLD_TRIG: rd_mux = trig_all[grp_idx];
        FLD_POL:  rd_mux = pol_all[grp_idx];
        FLD_REQ:  rd_mux = req_all[grp_idx];
        default:  rd_mux = '0;
      endcase
    end else if (addr_i == SUMMARY_ADDR) begin
      rd_mux = SRC_W'(pend);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
      irq_cpu_o  <= 1'b0;
      irq_nmi_o  <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
      irq_cpu_o  <= pend[GRP_LB] | pend[GRP_LPC] | pend[GRP_PCI];
      irq_nmi_o  <= pend[GRP_NMI];
    end
  end

  // R2: read data valid one cycle after the strobe
  p_rd_latency_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);

  // R9: a pending NMI group alone leaves the general line low
  p_cpu_no_nmi_r9: assert property (@(posedge clk) disable iff (rst)
    (pend == 4'b1000) |=> !irq_cpu_o);

  // R10: the NMI line tracks only its own group
  p_nmi_only_r10: assert property (@(posedge clk) disable iff (rst)
    !pend[GRP_NMI] |=> !irq_nmi_o);

  // R11: writing the summary address disturbs no configuration
  p_summary_ro_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == SUMMARY_ADDR) |=>
      ($stable(mask_all) && $stable(trig_all) && $stable(pol_all)));
endmodule

// File: tb/test_irq_group_ctrl.sv
module test_irq_group_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;
  logic [15:0] lb = 16'hFFFF, lpc = 16'hFFFF, pci = 16'hFFFF, nmi = 16'hFFFF;
  logic        irq_cpu, irq_nmi;

  int checks = 0;
  int failures = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  irq_group_ctrl i_irq_group_ctrl (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .src_lb_i(lb), .src_lpc_i(lpc), .src_pci_i(pci), .src_nmi_i(nmi),
    .irq_cpu_o(irq_cpu), .irq_nmi_o(irq_nmi)
  );

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // driver: issue a read and push the expected value to the scoreboard
  task automatic rd(logic [4:0] a, logic [15:0] exp, string tag);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  // monitor: pop and compare as read data appears
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) check("R2 unexpected read data", rdata, 16'hxxxx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic finish_run();
    repeat (3) @(negedge clk);
    check("R2 pending reads", 16'(exp_q.size()), 16'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    check("R1 irq_cpu", 16'(irq_cpu), 16'd0);
    check("R1 irq_nmi", 16'(irq_nmi), 16'd0);
    rd(5'h00, 16'hFFFF, "R1 lb mask");
    rd(5'h04, 16'hFFFF, "R1 lpc mask");
    rd(5'h08, 16'hFFFF, "R1 pci mask");
    rd(5'h0C, 16'hFFFF, "R1 nmi mask");
    rd(5'h05, 16'h0000, "R1 lpc trig");
    rd(5'h0A, 16'h0000, "R1 pci pol");
    rd(5'h10, 16'h0000, "R1 summary");
    // R2 write / readback
    wr(5'h09, 16'hA5A5);
    rd(5'h09, 16'hA5A5, "R2 pci trig readback");
    wr(5'h09, 16'h0000);
    rd(5'h09, 16'h0000, "R2 pci trig cleared");

    // R4 level active-high on local bus bit 0
    @(negedge clk); lb[0] = 1'b0;
    wr(5'h02, 16'h0001);
    wr(5'h00, 16'hFFFE);
    settle();
    rd(5'h03, 16'h0000, "R4 lb level inactive");
    check("R4 irq_cpu idle", 16'(irq_cpu), 16'd0);
    @(negedge clk); lb[0] = 1'b1;
    settle();
    rd(5'h03, 16'h0001, "R4 lb level active");
    rd(5'h10, 16'h0001, "R8 summary lb");
    check("R9 irq_cpu from lb", 16'(irq_cpu), 16'd1);
    @(negedge clk); lb[0] = 1'b0;
    settle();
    rd(5'h03, 16'h0000, "R4 lb level live drop");
    check("R4 irq_cpu drop", 16'(irq_cpu), 16'd0);

    // R5 falling-edge sticky on local bus bit 4 (polarity 0)
    wr(5'h01, 16'h0010);
    wr(5'h00, 16'hFFEE);
    @(negedge clk); lb[4] = 1'b0;
    settle();
    @(negedge clk); lb[4] = 1'b1;
    settle();
    rd(5'h03, 16'h0010, "R5 falling edge sticky");
    check("R5 irq_cpu edge", 16'(irq_cpu), 16'd1);
    // R6 acknowledge keeps level bits
    @(negedge clk); lb[0] = 1'b1;
    settle();
    wr(5'h03, 16'h0000);
    settle();
    rd(5'h03, 16'h0001, "R6 ack leaves level bit");
    @(negedge clk); lb[0] = 1'b0;
    settle();
    rd(5'h03, 16'h0000, "R6 lb cleared");

    // R3 masking in the PCI group, active-low level
    wr(5'h08, 16'hFFFB);
    @(negedge clk); pci[5] = 1'b0;
    settle();
    rd(5'h0B, 16'h0020, "R3 masked source visible");
    rd(5'h10, 16'h0000, "R3 masked source not summarised");
    check("R3 irq_cpu masked", 16'(irq_cpu), 16'd0);
    @(negedge clk); pci[2] = 1'b0;
    settle();
    rd(5'h0B, 16'h0024, "R3 pci request");
    rd(5'h10, 16'h0004, "R8 summary pci");
    check("R9 irq_cpu from pci", 16'(irq_cpu), 16'd1);
    @(negedge clk); pci[2] = 1'b1; pci[5] = 1'b1;
    settle();

    // LPC edge group, bits 1 and 12 active-high rising edge
    @(negedge clk); lpc[1] = 1'b0; lpc[12] = 1'b0;
    settle();
    rd(5'h07, 16'h1002, "R3 lpc level active-low while masked");
    wr(5'h06, 16'h1002);
    wr(5'h05, 16'h1002);
    wr(5'h04, 16'hEFFD);
    settle();
    rd(5'h07, 16'h0000, "R5 lpc no edge yet");
    @(negedge clk); lpc[1] = 1'b1;
    repeat (2) @(negedge clk); lpc[1] = 1'b0;
    settle();
    rd(5'h07, 16'h0002, "R5 rising edge sticky");
    rd(5'h10, 16'h0002, "R8 summary lpc");
    check("R9 irq_cpu from lpc", 16'(irq_cpu), 16'd1);
    @(negedge clk); lpc[12] = 1'b1;
    repeat (2) @(negedge clk); lpc[12] = 1'b0;
    settle();
    rd(5'h07, 16'h1002, "R5 second edge");
    wr(5'h07, 16'h1000);
    rd(5'h07, 16'h1000, "R6 partial acknowledge");
    wr(5'h07, 16'h0000);
    settle();
    rd(5'h07, 16'h0000, "R6 bulk acknowledge");
    check("R6 irq_cpu after ack", 16'(irq_cpu), 16'd0);

    // R7 edge coincident with acknowledge write
    @(negedge clk); lpc[1] = 1'b1;   // stage 1 at next edge
    @(negedge clk);                   // stage 2 at next edge
    wr(5'h07, 16'h0000);             // write lands on the edge that sets the latch
    settle();
    rd(5'h07, 16'h0002, "R7 coincident edge kept");
    @(negedge clk); lpc[1] = 1'b0;
    wr(5'h07, 16'h0000);
    settle();
    rd(5'h07, 16'h0000, "R7 cleared after");

    // R10 NMI group, active-low level
    wr(5'h0C, 16'hFFFE);
    @(negedge clk); nmi[0] = 1'b0;
    settle();
    check("R10 irq_nmi", 16'(irq_nmi), 16'd1);
    check("R9 irq_cpu not from nmi", 16'(irq_cpu), 16'd0);
    rd(5'h10, 16'h0008, "R8 summary nmi");
    // R11 summary write ignored
    wr(5'h10, 16'h0000);
    rd(5'h10, 16'h0008, "R11 summary unchanged");
    rd(5'h0C, 16'hFFFE, "R11 nmi mask unchanged");
    rd(5'h00, 16'hFFEE, "R11 lb mask unchanged");
    @(negedge clk); nmi[0] = 1'b1;
    settle();
    check("R10 irq_nmi drop", 16'(irq_nmi), 16'd0);
    finish_run();
  end
endmodule